// File: doc/BRIEF.md
# Register-Exchange Survivor Window

This block is the survivor memory of a Viterbi decoder built on the register-exchange principle. Every state of the trellis owns a shift register of decoded bits. When the add-compare-select stage hands over one decision bit per state, each new state copies the whole register of the predecessor that its decision picks, moves it one stage older and writes its own input bit as the newest stage. After enough steps all surviving paths agree on their old bits, so the oldest stage carries the decoded data.

One structure serves two trellis sizes. In the wide setting all 32 states take part. In the narrow setting only states 0 to 7 are used, and the predecessor selection of those eight registers is switched so they form a complete 8-state trellis on their own. The window is 36 stages deep. The delivered bit is a majority vote over the oldest stage of every active state, not the bit of a single best state, so no path metric comparison is needed here.

A decoder drives `dec_valid` with each decision vector. Once the window holds 36 steps, each further step yields one decoded bit one clock later.

Top module: `rex_survivor_window`

## Requirements
- R1: A synchronous active-high `rst` clears every state register, `out_valid` and `out_bit` to 0 at the clock edge where it is sampled.
- R2: On a clock edge with `dec_valid` high, new state s = 2i+j (j = bit 0 of s) loads the register of old state i if `decisions[s]` is 0, or of old state i+N/2 if it is 1, where N is 32 when `mode_wide` is 1 and 8 when it is 0. The copied contents move one stage older (stage k goes to stage k+1, the oldest stage 35 is dropped) and j is written into stage 0.
- R3: On a clock edge with `dec_valid` low, no state register changes and `out_valid` is low in the next cycle, whatever `decisions` holds.
- R4: With `mode_wide` at 0, `decisions[31:8]` have no effect on any result and state registers 8 to 31 keep their contents.
- R5: `out_valid` is high for exactly one cycle after each accepted step numbered 37 or later since reset, and never after steps 1 to 36.
- R6: `out_bit` is the majority of stage 35 over the N active state registers, taken before that step's shift; when exactly half of them are 1 the result is 1.
- R7: When every active decision bit of a step equals one level d_t, the bit delivered after step q equals d of step q-36+log2(N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_wide | input | 1 | 1 selects the 32-state trellis, 0 the 8-state trellis |
| dec_valid | input | 1 | Marks a decision vector to be taken this cycle |
| decisions | input | 32 | One survivor decision per new state, bit s for state s |
| out_valid | output | 1 | Decoded bit present on `out_bit` |
| out_bit | output | 1 | Majority-voted decoded bit |

## Verification
The decoded bit of step q appears on the port one clock after that step's edge, and only for q of 37 or more, carrying the level of step q-36+log2(N) when decisions are uniform, or 1 when the decisions form a non-merging rotation that splits the voters evenly. The driver queues one expectation per step from 37 on at the moment it presents that step, and the monitor compares on the falling edge that follows each rising edge, so every expectation meets exactly the pulse it belongs to; an output pulse with nothing queued, or an expectation still queued at the end, counts as a failure. Idle cycles with noisy decisions are spread through the stimulus so that a result due one clock after a step cannot be confused with one triggered by an idle cycle.

// File: rtl/rex_pkg.sv
package rex_pkg;

  // Default geometry of the survivor window.
  localparam int unsigned REX_STATES_WIDE   = 32;
  localparam int unsigned REX_STATES_NARROW = 8;
  localparam int unsigned REX_DEPTH         = 36;

  // Index of the predecessor a new state copies from.
  function automatic int unsigned rex_pred(input int unsigned s,
                                           input int unsigned n_states,
                                           input bit          upper);
    return (s / 2) + (upper ? (n_states / 2) : 0);
  endfunction

endpackage

// File: rtl/rex_fill_ctr.sv
module rex_fill_ctr #(
  parameter int unsigned DEPTH = rex_pkg::REX_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  output logic full
);
  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic [FW-1:0] cnt_q;

  assign full = (cnt_q == FW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rex_path_regs.sv
module rex_path_regs #(
  parameter int unsigned NS       = rex_pkg::REX_STATES_WIDE,
  parameter int unsigned NS_SMALL = rex_pkg::REX_STATES_NARROW,
  parameter int unsigned DEPTH    = rex_pkg::REX_DEPTH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic                      wide,
  input  logic [NS-1:0]             dec,
  output logic [NS-1:0][DEPTH-1:0]  path
);
  import rex_pkg::*;

  for (genvar s = 0; s < NS; s++) begin : g_state
    localparam int unsigned P_LO   = rex_pred(s, NS, 1'b0);
    localparam int unsigned P_HI_W = rex_pred(s, NS, 1'b1);
    localparam logic        NEW_B  = (s % 2) == 1;

    logic [DEPTH-1:0] row_q;
    logic [DEPTH-1:0] src;
    logic             en;

    if (s < NS_SMALL) begin : g_shared
      // Shared rows: the upper predecessor depends on the trellis size.
      localparam int unsigned P_HI_N = rex_pred(s, NS_SMALL, 1'b1);
      logic [DEPTH-1:0] hi_src;
      assign hi_src = wide ? path[P_HI_W] : path[P_HI_N];
      assign src    = dec[s] ? hi_src : path[P_LO];
      assign en     = push;
    end else begin : g_wide_only
      assign src = dec[s] ? path[P_HI_W] : path[P_LO];
      assign en  = push & wide;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= '0;
      end else if (en) begin
        row_q <= {src[DEPTH-2:0], NEW_B};
      end
    end

    assign path[s] = row_q;
  end
endmodule

// File: rtl/rex_vote.sv
module rex_vote #(
  parameter int unsigned NS       = rex_pkg::REX_STATES_WIDE,
  parameter int unsigned NS_SMALL = rex_pkg::REX_STATES_NARROW,
  parameter int unsigned DEPTH    = rex_pkg::REX_DEPTH
) (
  input  logic                     wide,
  input  logic [NS-1:0][DEPTH-1:0] path,
  output logic                     maj
);
  localparam int unsigned CW = $clog2(NS + 1);

  logic [CW-1:0] ones;
  logic [CW-1:0] voters;

  always_comb begin
    ones = '0;
    for (int s = 0; s < NS; s++) begin
      if (wide || (s < int'(NS_SMALL))) begin
        ones = ones + CW'(path[s][DEPTH-1]);
      end
    end
  end

  assign voters = wide ? CW'(NS) : CW'(NS_SMALL);
  // Twice the ones against the voter count; equality (a tie) gives 1.
  assign maj = ({ones, 1'b0} >= {1'b0, voters});
endmodule

// File: rtl/rex_survivor_window.sv
module rex_survivor_window #(
  parameter int unsigned NS       = rex_pkg::REX_STATES_WIDE,
  parameter int unsigned NS_SMALL = rex_pkg::REX_STATES_NARROW,
  parameter int unsigned DEPTH    = rex_pkg::REX_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wide,
  input  logic          dec_valid,
  input  logic [NS-1:0] decisions,
  output logic          out_valid,
  output logic          out_bit
);
  logic [NS-1:0][DEPTH-1:0] path_w;
  logic                     full_w;
  logic                     maj_w;
  logic                     emit;

  rex_path_regs #(.NS(NS), .NS_SMALL(NS_SMALL), .DEPTH(DEPTH)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .push (dec_valid),
    .wide (mode_wide),
    .dec  (decisions),
    .path (path_w)
  );

  rex_fill_ctr #(.DEPTH(DEPTH)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .push (dec_valid),
    .full (full_w)
  );

  rex_vote #(.NS(NS), .NS_SMALL(NS_SMALL), .DEPTH(DEPTH)) u_vote (
    .wide (mode_wide),
    .path (path_w),
    .maj  (maj_w)
  );

  assign emit = dec_valid & full_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_bit <= maj_w;
      end
    end
  end
endmodule

// File: rtl/rex_survivor_window_chk.sv
module rex_survivor_window_chk #(
  parameter int unsigned NS       = 32,
  parameter int unsigned NS_SMALL = 8,
  parameter int unsigned DEPTH    = 36
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     push,
  input logic                     wide,
  input logic [NS-1:0]            dec,
  input logic [NS-1:0][DEPTH-1:0] path,
  input logic                     out_valid,
  input logic                     out_bit
);
  localparam int unsigned SW = $clog2(DEPTH + 2);

  logic [SW-1:0] steps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      steps_q <= '0;
    end else if (push && steps_q <= SW'(DEPTH)) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  assert_clear_on_reset_R1: assert property (@(posedge clk)
    rst |=> (path == '0) && !out_valid && !out_bit);

  assert_state0_lower_copy_R2: assert property (@(posedge clk) disable iff (rst)
    (push && !dec[0]) |=> path[0] == {$past(path[0][DEPTH-2:0]), 1'b0});

  assert_state1_upper_copy_R2: assert property (@(posedge clk) disable iff (rst)
    (push && dec[1]) |=> path[1] == {$past(wide ? path[NS/2][DEPTH-2:0]
                                               : path[NS_SMALL/2][DEPTH-2:0]), 1'b1});

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(path) && !out_valid);

  assert_narrow_upper_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wide |=> $stable(path[NS-1:NS_SMALL]));

  assert_valid_follows_step_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(push));

  assert_valid_after_fill_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (steps_q > SW'(DEPTH)));
endmodule

bind rex_survivor_window rex_survivor_window_chk #(
  .NS(NS), .NS_SMALL(NS_SMALL), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push      (dec_valid),
  .wide      (mode_wide),
  .dec       (decisions),
  .path      (path_w),
  .out_valid (out_valid),
  .out_bit   (out_bit)
);

// File: tb/rex_survivor_window_test.sv
module rex_survivor_window_test;
  localparam int NS    = 32;
  localparam int NSN   = 8;
  localparam int DEPTH = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_wide = 1'b0;
  logic          dec_valid = 1'b0;
  logic [NS-1:0] decisions = '0;
  logic          out_valid;
  logic          out_bit;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];
  string tag_q[$];
  bit hist [0:511];

  always #5 clk = ~clk;

  rex_survivor_window uut (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .dec_valid(dec_valid),
    .decisions(decisions), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expectation per output pulse.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 pulse with nothing due", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_bit == e, t, out_bit, e);
      end
    end
  end

  task automatic do_reset(input bit wide);
    @(posedge clk); #1;
    rst = 1'b1; dec_valid = 1'b0; mode_wide = wide; decisions = $urandom();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: outputs cleared after reset
    check(out_valid == 1'b0 && out_bit == 1'b0, "R1 reset outputs", {out_valid, out_bit}, 0);
  endtask

  task automatic idle_cycle;
    @(posedge clk); #1;
    dec_valid = 1'b0;
    decisions = $urandom();   // R3: noise while idle must do nothing
  endtask

  // Uniform decisions per step; R7 (and R2, R4 with junk upper bits in narrow mode).
  task automatic run_uniform(input bit wide, input int n, input int gap_every);
    int lg;
    lg = wide ? 5 : 3;
    do_reset(wide);
    for (int q = 1; q <= n; q++) begin
      bit d;
      d = 1'($urandom());
      hist[q] = d;
      @(posedge clk); #1;
      dec_valid = 1'b1;
      if (wide) decisions = d ? '1 : '0;
      else decisions = {24'($urandom()), (d ? 8'hFF : 8'h00)};
      if (q > DEPTH) begin
        exp_q.push_back(hist[q - DEPTH + lg]);
        tag_q.push_back(wide ? "R7 wide uniform" : "R7/R4 narrow uniform");
      end
      if (gap_every > 0 && (q % gap_every) == 0) idle_cycle();
    end
    idle_cycle();
    repeat (3) @(posedge clk);
  endtask

  // Rotating decisions: paths never merge, half the voters are 1 (R6 tie to 1).
  task automatic run_rotate(input bit wide, input int n);
    do_reset(wide);
    for (int q = 1; q <= n; q++) begin
      @(posedge clk); #1;
      dec_valid = 1'b1;
      decisions = wide ? {16{2'b10}} : {24'($urandom()), {4{2'b10}}};
      if (q > DEPTH) begin
        exp_q.push_back(1'b1);
        tag_q.push_back("R6 tie resolves to 1");
      end
    end
    idle_cycle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run_uniform(1'b0, 120, 0);
    run_uniform(1'b1, 120, 0);
    run_uniform(1'b1, 100, 4);
    run_uniform(1'b0, 100, 3);
    run_rotate(1'b0, 80);
    run_rotate(1'b1, 80);
    // R5: every due result was delivered
    check(exp_q.size() == 0, "R5 results outstanding", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule